// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block walks the register indices of one short-vector floating-point operation. A start strobe supplies a first register number, a precision select, a requested iteration count, a stride and a transfer mode. From the next cycle on, the block emits one 5-bit register index per clock with a valid strobe. A done flag marks the final index.

In vector mode the index wraps around inside the bank that holds the first register. Single-precision banks hold eight registers and double-precision banks hold four. The stride is added before the wrap. An operand whose first register sits in the lowest bank of its register set is scalar, and its index is repeated on every iteration.

In linear mode, which serves multi-register loads and stores, the index simply counts up by one across the whole 32-entry file. A requested length outside the legal range for the chosen mode gives a one-cycle error pulse and no indices.

The controller has three states:
- IDLE waits for a start strobe.
- RUN emits indices.
- LENERR carries the error pulse.

Its transitions are:
- IDLE to RUN on a start with a legal length.
- IDLE to LENERR on a start with an illegal length.
- RUN to RUN on a legal start in the done cycle.
- RUN to LENERR on an illegal start in the done cycle.
- RUN to IDLE after the last index with no start.
- LENERR to IDLE always.

Top module: `vis_top`

## Requirements
- R1: After reset `valid_o`, `done_o` and `len_err_o` are low until a start is accepted.
- R2: Single precision (`prec_dbl_i`=0), vector mode, stride 1: the index is bits [4:3] of the first register concatenated with (bits [2:0] + k) mod 8, for iteration k = 0, 1, 2 and so on.
- R3: Double precision (`prec_dbl_i`=1), vector mode, stride 1: the index is bits [4:2] of the first register concatenated with (bits [1:0] + k) mod 4.
- R4: Double registers 16 to 31 form banks 4 to 7 and wrap exactly like banks 0 to 3. For example, a start at 31 gives 31, 28.
- R5: In vector mode, a first register with bits [4:3]=0 (single), or with bits [3:2]=0 (double, banks 0 and 4), is scalar. It gives the same index on every iteration.
- R6: `stride_i`=1 selects a step of 2 and `stride_i`=0 a step of 1. The step is added before the modulo-bank wrap. For example, single from 14 with 4 iterations gives 14, 8, 10, 12.
- R7: The legal length `len_i` (iteration count) is 1 to 8 for single vectors, 2 to 4 for double vectors and 1 to 15 in linear mode. Any other length gives `len_err_o` high for exactly the one cycle after the start, and `valid_o` stays low.
- R8: Linear mode (`linear_i`=1) gives first register + k modulo 32. It ignores precision, stride, banks and scalar detection.
- R9: The first index appears in the cycle after the accepted start. `valid_o` is high for exactly `len_i` consecutive cycles, and `done_o` is high only with the last of them.
- R10: A start that arrives while indices are being emitted, before the done cycle, is ignored. A start in the done cycle is accepted, and its first index follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled with the configuration below |
| prec_dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| linear_i | input | 1 | 1 = linear multi-register transfer mode |
| stride_i | input | 1 | 0 = step 1, 1 = step 2 (vector mode) |
| start_reg_i | input | 5 | First register number |
| len_i | input | 4 | Requested number of iterations |
| idx_o | output | 5 | Register index of the current iteration |
| valid_o | output | 1 | Index is valid this cycle |
| done_o | output | 1 | This cycle carries the final index |
| len_err_o | output | 1 | Illegal length pulse |

## Verification
The final index of one sequence and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising the start strobe exactly in the cycle where `done_o` is high. It then checks that the new sequence's first index appears in the very next cycle, with no idle gap. It also checks that an illegal length given at that moment turns into an error pulse rather than indices. A start raised one cycle earlier, before done, must leave the running sequence untouched.

// File: rtl/vis_pkg.sv
package vis_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_LENERR = 2'd2
    } vis_state_e;

    typedef struct packed {
        logic linear;
        logic dbl;
        logic stride2;
    } vis_mode_t;

endpackage

// File: rtl/vis_len_check.sv
module vis_len_check
    import vis_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int SP_MAX  = 8,
    parameter int DP_MIN  = 2,
    parameter int DP_MAX  = 4,
    parameter int LIN_MAX = 15
) (
    input  vis_mode_t        mode,
    input  logic [LEN_W-1:0] len,
    output logic             ok
);

    always_comb begin
        if (mode.linear)
            ok = (len != '0) && (int'(len) <= LIN_MAX);
        else if (mode.dbl)
            ok = (int'(len) >= DP_MIN) && (int'(len) <= DP_MAX);
        else
            ok = (len != '0) && (int'(len) <= SP_MAX);
    end

endmodule

// File: rtl/vis_step_cnt.sv
module vis_step_cnt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [LEN_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (advance)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/vis_addr_gen.sv
module vis_addr_gen
    import vis_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int SP_OFF_W = 3,
    parameter int DP_OFF_W = 2,
    parameter int LEN_W    = 4
) (
    input  vis_mode_t        mode,
    input  logic [REG_W-1:0] base,
    input  logic [LEN_W-1:0] cnt,
    output logic [REG_W-1:0] idx,
    output logic             scalar
);

    localparam int STEP_W = LEN_W + 1;

    logic [STEP_W-1:0] step;
    logic [REG_W-1:0]  wrap_v   [2];
    logic              scalar_v [2];

    assign step = mode.stride2 ? {cnt, 1'b0} : {1'b0, cnt};

    // p = 0: single-precision banks, p = 1: double-precision banks
    for (genvar p = 0; p < 2; p++) begin : g_prec
        localparam int OW = (p == 1) ? DP_OFF_W : SP_OFF_W;
        // double banks ignore the set bit when deciding scalar
        localparam int HI = (p == 1) ? REG_W - 2 : REG_W - 1;
        logic [OW-1:0] off;
        assign off         = base[OW-1:0] + step[OW-1:0];
        assign wrap_v[p]   = {base[REG_W-1:OW], off};
        assign scalar_v[p] = (base[HI:OW] == '0);
    end

    always_comb begin
        scalar = scalar_v[mode.dbl];
        if (mode.linear)
            idx = base + REG_W'(cnt);
        else if (scalar)
            idx = base;
        else
            idx = wrap_v[mode.dbl];
    end

endmodule

// File: rtl/vis_top.sv
module vis_top
    import vis_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int SP_OFF_W = 3,
    parameter int DP_OFF_W = 2,
    parameter int LEN_W    = 4,
    parameter int SP_MAX   = 8,
    parameter int DP_MIN   = 2,
    parameter int DP_MAX   = 4,
    parameter int LIN_MAX  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             prec_dbl_i,
    input  logic             linear_i,
    input  logic             stride_i,
    input  logic [REG_W-1:0] start_reg_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [REG_W-1:0] idx_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             len_err_o
);

    vis_state_e       state_q, state_d;
    vis_mode_t        mode_in, mode_q;
    logic [REG_W-1:0] base_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt;
    logic [REG_W-1:0] gen_idx;
    logic             gen_scalar;
    logic             len_ok;
    logic             last;
    logic             accept;

    assign mode_in = '{linear: linear_i, dbl: prec_dbl_i, stride2: stride_i};

    vis_len_check #(
        .LEN_W(LEN_W), .SP_MAX(SP_MAX), .DP_MIN(DP_MIN),
        .DP_MAX(DP_MAX), .LIN_MAX(LIN_MAX)
    ) u_len (
        .mode(mode_in),
        .len (len_i),
        .ok  (len_ok)
    );

    assign last   = ({1'b0, cnt} + 1'b1) == {1'b0, len_q};
    assign accept = start_i && ((state_q == ST_IDLE) ||
                                (state_q == ST_RUN && last));

    vis_step_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .advance(state_q == ST_RUN),
        .cnt    (cnt)
    );

    vis_addr_gen #(
        .REG_W(REG_W), .SP_OFF_W(SP_OFF_W),
        .DP_OFF_W(DP_OFF_W), .LEN_W(LEN_W)
    ) u_gen (
        .mode  (mode_q),
        .base  (base_q),
        .cnt   (cnt),
        .idx   (gen_idx),
        .scalar(gen_scalar)
    );

    // configuration capture on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            base_q <= '0;
            len_q  <= '0;
        end else if (accept) begin
            mode_q <= mode_in;
            base_q <= start_reg_i;
            len_q  <= len_i;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_d = len_ok ? ST_RUN : ST_LENERR;
            end
            ST_RUN: begin
                if (last) begin
                    if (start_i)
                        state_d = len_ok ? ST_RUN : ST_LENERR;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_LENERR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        valid_o   = 1'b0;
        done_o    = 1'b0;
        len_err_o = 1'b0;
        idx_o     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                valid_o = 1'b1;
                done_o  = last;
                idx_o   = gen_idx;
            end
            ST_LENERR: len_err_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vis_top_chk.sv
module vis_top_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_o,
    input logic             done_o,
    input logic             len_err_o,
    input logic [REG_W-1:0] idx_o,
    input logic             lin,
    input logic             dbl,
    input logic             scalar
);

    // R9: done only accompanies a valid index
    a_r9_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

    // R10: a running sequence keeps going until its done cycle
    a_r10_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o) |=> valid_o);

    // R7: the error pulse never carries an index and lasts one cycle
    a_r7_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !valid_o);

    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |=> !len_err_o);

    // R2: single vector indices stay in their bank of eight
    a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(done_o) && !lin && !dbl)
        |-> idx_o[REG_W-1:3] == $past(idx_o[REG_W-1:3]));

    // R3: double vector indices stay in their bank of four
    a_r3_double_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(done_o) && !lin && dbl)
        |-> idx_o[REG_W-1:2] == $past(idx_o[REG_W-1:2]));

    // R5: scalar operand repeats its index
    a_r5_scalar_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(done_o) && !lin && scalar)
        |-> idx_o == $past(idx_o));

    // R8: linear mode steps by exactly one
    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(done_o) && lin)
        |-> idx_o == $past(idx_o) + 1'b1);

endmodule

bind vis_top vis_top_chk #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_o  (valid_o),
    .done_o   (done_o),
    .len_err_o(len_err_o),
    .idx_o    (idx_o),
    .lin      (mode_q.linear),
    .dbl      (mode_q.dbl),
    .scalar   (gen_scalar)
);

// File: tb/vis_top_tb.sv
`timescale 1ns/1ps
module vis_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       prec_dbl_i = 1'b0;
    logic       linear_i = 1'b0;
    logic       stride_i = 1'b0;
    logic [4:0] start_reg_i = '0;
    logic [3:0] len_i = '0;
    logic [4:0] idx_o;
    logic       valid_o, done_o, len_err_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vis_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_dbl_i(prec_dbl_i),
        .linear_i(linear_i), .stride_i(stride_i), .start_reg_i(start_reg_i),
        .len_i(len_i), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o),
        .len_err_o(len_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected index from the requirements
    function automatic logic [4:0] model(input logic [4:0] b, input bit dbl,
                                         input bit lin, input bit s2, input int k);
        int st;
        logic [2:0] o3;
        logic [1:0] o2;
        st = s2 ? 2 : 1;
        if (lin) return 5'(int'(b) + k);
        if (dbl) begin
            if (b[3:2] == 2'b00) return b;
            o2 = 2'(int'(b[1:0]) + k * st);
            return {b[4:2], o2};
        end
        if (b[4:3] == 2'b00) return b;
        o3 = 3'(int'(b[2:0]) + k * st);
        return {b[4:3], o3};
    endfunction

    task automatic drive(input logic [4:0] b, input bit dbl, input bit lin,
                         input bit s2, input int n);
        start_reg_i = b; prec_dbl_i = dbl; linear_i = lin;
        stride_i = s2; len_i = 4'(n); start_i = 1'b1;
    endtask

    // checks an emitted sequence; we are at the negedge holding index 0
    task automatic check_run(input logic [4:0] b, input bit dbl, input bit lin,
                             input bit s2, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [4:0] e;
            e = model(b, dbl, lin, s2, k);
            chk(valid_o === 1'b1, {req, " valid"}, int'(valid_o), 1);
            chk(idx_o === e, {req, " idx"}, int'(idx_o), int'(e));
            chk(done_o === (k == n - 1), "R9 done", int'(done_o), int'(k == n - 1));
            @(negedge clk);
        end
    endtask

    task automatic run_seq(input logic [4:0] b, input bit dbl, input bit lin,
                           input bit s2, input int n, input string req);
        @(negedge clk);
        drive(b, dbl, lin, s2, n);
        @(negedge clk);
        start_i = 1'b0;
        check_run(b, dbl, lin, s2, n, req);
        chk(valid_o === 1'b0, "R9 valid after end", int'(valid_o), 0);
    endtask

    task automatic illegal(input bit dbl, input bit lin, input int n);
        @(negedge clk);
        drive(5'd13, dbl, lin, 1'b0, n);
        @(negedge clk);
        start_i = 1'b0;
        chk(len_err_o === 1'b1, "R7 err pulse", int'(len_err_o), 1);
        chk(valid_o === 1'b0, "R7 no valid", int'(valid_o), 0);
        @(negedge clk);
        chk(len_err_o === 1'b0, "R7 err one cycle", int'(len_err_o), 0);
        chk(valid_o === 1'b0, "R7 still no valid", int'(valid_o), 0);
    endtask

    task automatic test_reset();
        chk(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
        chk(done_o === 1'b0, "R1 done", int'(done_o), 0);
        chk(len_err_o === 1'b0, "R1 len_err", int'(len_err_o), 0);
    endtask

    task automatic test_ignore_mid();
        // R10: start during a run, before done, has no effect
        @(negedge clk);
        drive(5'd13, 1'b0, 1'b0, 1'b0, 4);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [4:0] e;
            e = model(5'd13, 1'b0, 1'b0, 1'b0, k);
            chk(idx_o === e, "R10 idx kept", int'(idx_o), int'(e));
            chk(done_o === (k == 3), "R10 done", int'(done_o), int'(k == 3));
            if (k == 1) drive(5'd30, 1'b1, 1'b1, 1'b1, 2);
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(valid_o === 1'b0, "R10 ignored start", int'(valid_o), 0);
    endtask

    task automatic test_back_to_back();
        // R10: start in done cycle accepted, then illegal start in done cycle
        @(negedge clk);
        drive(5'd6, 1'b1, 1'b0, 1'b0, 2);
        @(negedge clk);
        start_i = 1'b0;
        chk(idx_o === 5'd6, "R10 first A", int'(idx_o), 6);
        @(negedge clk);
        chk(done_o === 1'b1, "R10 done A", int'(done_o), 1);
        drive(5'd22, 1'b0, 1'b0, 1'b1, 3);
        @(negedge clk);
        start_i = 1'b0;
        check_run(5'd22, 1'b0, 1'b0, 1'b1, 3, "R10 back-to-back");
        chk(valid_o === 1'b0, "R10 idle after B", int'(valid_o), 0);
        @(negedge clk);
        drive(5'd9, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        chk(done_o === 1'b1, "R10 done C", int'(done_o), 1);
        drive(5'd9, 1'b1, 1'b0, 1'b0, 5);
        @(negedge clk);
        start_i = 1'b0;
        chk(len_err_o === 1'b1, "R10 R7 err after done", int'(len_err_o), 1);
        chk(valid_o === 1'b0, "R10 R7 no valid", int'(valid_o), 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_seq(5'd13, 1'b0, 1'b0, 1'b0, 5, "R2 single wrap");
        run_seq(5'd8,  1'b0, 1'b0, 1'b0, 8, "R2 single full");
        run_seq(5'd6,  1'b1, 1'b0, 1'b0, 4, "R3 double wrap");
        run_seq(5'd18, 1'b1, 1'b0, 1'b0, 3, "R4 upper bank");
        run_seq(5'd31, 1'b1, 1'b0, 1'b0, 2, "R4 upper top");
        run_seq(5'd3,  1'b0, 1'b0, 1'b0, 4, "R5 single scalar");
        run_seq(5'd17, 1'b1, 1'b0, 1'b0, 3, "R5 double bank4 scalar");
        run_seq(5'd2,  1'b1, 1'b0, 1'b1, 2, "R5 double bank0 scalar");
        run_seq(5'd14, 1'b0, 1'b0, 1'b1, 4, "R6 stride single");
        run_seq(5'd9,  1'b1, 1'b0, 1'b1, 3, "R6 stride double");
        run_seq(5'd6,  1'b1, 1'b1, 1'b1, 5, "R8 linear");
        run_seq(5'd30, 1'b0, 1'b1, 1'b0, 3, "R8 linear wrap");
        run_seq(5'd1,  1'b0, 1'b1, 1'b0, 15, "R8 R7 linear max");
        illegal(1'b0, 1'b0, 9);
        illegal(1'b0, 1'b0, 0);
        illegal(1'b1, 1'b0, 1);
        illegal(1'b1, 1'b0, 5);
        illegal(1'b0, 1'b1, 0);
        test_ignore_mid();
        test_back_to_back();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule